// File: doc/BRIEF.md
# Integer Dispersion Threshold Unit

This block decides, for every pixel of an image stream, whether that pixel is a strong spot candidate. Upstream logic supplies, for each pixel, its own value together with three statistics of the square window around it: how many window pixels are valid, their sum, and the sum of their squares. The block returns one hit bit per pixel. A hit means the window's spread is clearly wider than counting noise would give, and the pixel itself stands clearly above the window mean.

Both tests are written as squared integer comparisons, with the detection thresholds (six sigma for the window spread, three sigma for the pixel) folded into constant factors. There is no square root, no division and no floating point. Every stage is a plain register stage, so the unit takes a new pack of four pixels on every clock and never stalls. A valid flag travels with each pack at a fixed latency of three clocks. Intermediate widths are sized so that 16-bit pixels and windows of up to 63 pixels, which covers 7x7, never overflow.

Top module: `disp_thresh`

## Requirements
- R1: A lane whose pixel value is 0 produces hit 0, whatever its window statistics are.
- R2: A lane whose valid count m is 0 or 1 produces hit 0. With m = 2 a hit is possible.
- R3: The spread test passes only when B = m·q − s² − s·(m−1) is strictly positive and B² is strictly greater than 72·s²·(m−1). Here s is the window sum and q is the window squared sum.
- R4: The pixel test passes only when F = m·p − s is strictly positive and F² is strictly greater than 9·s·m.
- R5: The hit bit of a lane is the AND of its spread test and its pixel test. Lanes are independent. Lane i uses in_pix[16i+:16], in_cnt[6i+:6], in_sum[22i+:22] and in_sq[38i+:38], and drives out_hit[i].
- R6: A pack is accepted on every clock where in_valid is 1, including back-to-back clocks. Its result appears with out_valid = 1 exactly three rising edges later: the edge that samples the pack, plus two more.
- R7: While out_valid is 0, out_hit is all zeros.
- R8: Results are exact over the full range: 16-bit pixels, m up to 49, s up to 49·65535 and q up to 49·65535².
- R9: While reset is asserted, and right after it is released, out_valid and out_hit are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | The input pack is valid on this clock |
| in_pix | input | 64 | Pixel value p for each of the 4 lanes, 16 bits each |
| in_cnt | input | 24 | Window valid count m for each lane, 6 bits each |
| in_sum | input | 88 | Window sum s for each lane, 22 bits each |
| in_sq | input | 152 | Window squared sum q for each lane, 38 bits each |
| out_valid | output | 1 | The result pack is valid |
| out_hit | output | 4 | Spot candidate bit for each lane |

## Verification
Two situations have to be covered in the same cycle. First, one pack can contain lanes that fail on different tests, such as the pixel gate, the count gate, only the spread test or only the pixel test, next to lanes that hit. This is provoked with directed packs that mix these cases across the four lanes, and each lane is judged against its own hand-derived bit. Second, a new pack can enter while an older pack is leaving the pipeline. This is provoked by long back-to-back streams of generated windows with idle gaps between them. Each result is judged against an independent wide-integer model of the two tests, and out_valid is compared against the bench's own three-edge delay of in_valid.

// File: rtl/disp_thresh.sv
module disp_thresh #(
  parameter int LANES = 4,
  parameter int PIX_W = 16,
  parameter int CNT_W = 6,
  parameter int SUM_W = 22,
  parameter int SQ_W  = 38
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [LANES*PIX_W-1:0] in_pix,
  input  logic [LANES*CNT_W-1:0] in_cnt,
  input  logic [LANES*SUM_W-1:0] in_sum,
  input  logic [LANES*SQ_W-1:0]  in_sq,
  output logic                   out_valid,
  output logic [LANES-1:0]       out_hit
);
  localparam int MQ_W  = CNT_W + SQ_W;
  localparam int SS_W  = 2 * SUM_W;
  localparam int SM_W  = SUM_W + CNT_W;
  localparam int MP_W  = CNT_W + PIX_W;
  localparam int BG_W  = (MQ_W > SS_W ? MQ_W : SS_W) + 2;
  localparam int BQ_W  = 2 * BG_W;
  localparam int BR_W  = SS_W + CNT_W + 7;
  localparam int FG_W  = (MP_W > SUM_W ? MP_W : SUM_W) + 2;
  localparam int FQ_W  = 2 * FG_W;
  localparam int FR_W  = SM_W + 4;

  logic v1, v2;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      v1 <= in_valid;
      v2 <= v1;
      out_valid <= v2;
    end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    wire [PIX_W-1:0] p = in_pix[i*PIX_W +: PIX_W];
    wire [CNT_W-1:0] m = in_cnt[i*CNT_W +: CNT_W];
    wire [SUM_W-1:0] s = in_sum[i*SUM_W +: SUM_W];
    wire [SQ_W-1:0]  q = in_sq[i*SQ_W +: SQ_W];
    wire [CNT_W-1:0] m1 = (m == '0) ? '0 : m - 1'b1;

    logic [MQ_W-1:0]  a_mq;
    logic [SS_W-1:0]  a_ss;
    logic [SM_W-1:0]  a_sm1, a_sm;
    logic [MP_W-1:0]  a_mp;
    logic [SUM_W-1:0] a_s;
    logic [CNT_W-1:0] a_m1;
    logic             a_ok;

    always_ff @(posedge clk) begin
      a_mq  <= MQ_W'(m) * MQ_W'(q);
      a_ss  <= SS_W'(s) * SS_W'(s);
      a_sm1 <= SM_W'(s) * SM_W'(m1);
      a_sm  <= SM_W'(s) * SM_W'(m);
      a_mp  <= MP_W'(m) * MP_W'(p);
      a_s   <= s;
      a_m1  <= m1;
      a_ok  <= (p != '0) && (m >= CNT_W'(2));
    end

    logic signed [BG_W-1:0] b_bg;
    logic signed [FG_W-1:0] b_fg;
    logic [BR_W-1:0]        b_br;
    logic [FR_W-1:0]        b_fr;
    logic                   b_ok;

    always_ff @(posedge clk) begin
      b_bg <= $signed(BG_W'(a_mq) - BG_W'(a_ss) - BG_W'(a_sm1));
      b_fg <= $signed(FG_W'(a_mp) - FG_W'(a_s));
      b_br <= BR_W'(a_ss) * BR_W'(a_m1) * BR_W'(72);
      b_fr <= FR_W'(a_sm) * FR_W'(9);
      b_ok <= a_ok;
    end

    wire [BQ_W-1:0] bg_sq = BQ_W'(unsigned'(b_bg)) * BQ_W'(unsigned'(b_bg));
    wire [FQ_W-1:0] fg_sq = FQ_W'(unsigned'(b_fg)) * FQ_W'(unsigned'(b_fg));
    wire bg_pass = (b_bg > 0) && (bg_sq > BQ_W'(b_br));
    wire fg_pass = (b_fg > 0) && (fg_sq > FQ_W'(b_fr));

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) out_hit[i] <= 1'b0;
      else        out_hit[i] <= v2 && b_ok && bg_pass && fg_pass;
  end
endmodule

module disp_thresh_chk #(
  parameter int LANES = 4,
  parameter int PIX_W = 16,
  parameter int CNT_W = 6
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic [LANES*PIX_W-1:0] in_pix,
  input logic [LANES*CNT_W-1:0] in_cnt,
  input logic                   out_valid,
  input logic [LANES-1:0]       out_hit
);
  logic [1:0] cyc;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;

  p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_hit == '0));

  for (genvar i = 0; i < LANES; i++) begin : g_chk
    p_pix_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc == 2'd3 && $past(in_valid, 3) && $past(in_pix[i*PIX_W +: PIX_W], 3) == '0)
        |-> !out_hit[i]);

    p_cnt_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc == 2'd3 && $past(in_valid, 3) && $past(in_cnt[i*CNT_W +: CNT_W], 3) < CNT_W'(2))
        |-> !out_hit[i]);
  end
endmodule

bind disp_thresh disp_thresh_chk #(.LANES(LANES), .PIX_W(PIX_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pix(in_pix),
  .in_cnt(in_cnt), .out_valid(out_valid), .out_hit(out_hit));

// File: tb/disp_thresh_tb.sv
module disp_thresh_tb;
  localparam int L = 4;
  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [L*16-1:0] in_pix = '0;
  logic [L*6-1:0]  in_cnt = '0;
  logic [L*22-1:0] in_sum = '0;
  logic [L*38-1:0] in_sq  = '0;
  logic out_valid;
  logic [L-1:0] out_hit;

  int total = 0, bad = 0;
  bit done = 0;
  logic [3:0] expq[$];
  string tagq[$];
  logic [2:0] hist;

  always #4 clk = ~clk;

  disp_thresh u_dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pix(in_pix),
    .in_cnt(in_cnt), .in_sum(in_sum), .in_sq(in_sq), .out_valid(out_valid), .out_hit(out_hit));

  task automatic chk(bit ok, string tag, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit model(longint p, longint m, longint s, longint q);
    logic signed [127:0] P, M, S, Q, B, F;
    P = 128'(p); M = 128'(m); S = 128'(s); Q = 128'(q);
    if (P == 0 || M < 2) return 1'b0;
    B = M * Q - S * S - S * (M - 1);
    F = M * P - S;
    return (B > 0) && (B * B > 72 * S * S * (M - 1)) && (F > 0) && (F * F > 9 * S * M);
  endfunction

  always @(posedge clk or negedge rst_n)
    if (!rst_n) hist <= '0;
    else hist <= {hist[1:0], in_valid};

  always @(negedge clk) if (rst_n && !done) begin
    chk(out_valid == hist[2], "R6 valid latency", out_valid, hist[2]);
    if (!out_valid)
      chk(out_hit == '0, "R7 idle hit zero", out_hit, 0);
    else if (expq.size() == 0)
      chk(1'b0, "R6 unexpected pack", out_hit, 0);
    else begin
      automatic logic [3:0] e = expq.pop_front();
      automatic string t = tagq.pop_front();
      chk(out_hit == e, t, out_hit, e);
    end
  end

  task automatic set_lane(int i, longint p, longint m, longint s, longint q);
    in_pix[i*16 +: 16] = 16'(p);
    in_cnt[i*6 +: 6]   = 6'(m);
    in_sum[i*22 +: 22] = 22'(s);
    in_sq[i*38 +: 38]  = 38'(q);
  endtask

  task automatic push(logic [3:0] e, string t);
    in_valid = 1'b1;
    expq.push_back(e);
    tagq.push_back(t);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    repeat (5) @(negedge clk);
    chk(expq.size() == 0, "R6 all packs returned", expq.size(), 0);
  endtask

  task automatic t_reset();
    chk(out_valid == 1'b0 && out_hit == '0, "R9 in reset", {out_valid, out_hit}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(out_valid == 1'b0 && out_hit == '0, "R9 after release", {out_valid, out_hit}, 0);
    @(negedge clk);
    chk(out_valid == 1'b0 && out_hit == '0, "R9 one cycle on", {out_valid, out_hit}, 0);
  endtask

  task automatic t_mixed();
    set_lane(0, 200, 49, 680, 44800);
    set_lane(1, 10, 49, 490, 4900);
    set_lane(2, 100, 2, 100, 10000);
    set_lane(3, 100, 1, 100, 10000);
    push(4'b0101, "R5 R2 mixed lanes");
    drain();
  endtask

  task automatic t_pix_zero();
    for (int i = 0; i < L; i++) set_lane(i, 0, 49, 680, 44800);
    push(4'b0000, "R1 zero pixel");
    set_lane(0, 200, 0, 680, 44800);
    set_lane(1, 200, 1, 680, 44800);
    set_lane(2, 200, 49, 680, 44800);
    set_lane(3, 0, 2, 100, 10000);
    push(4'b0100, "R2 R1 count gate");
    drain();
  endtask

  task automatic t_single_test();
    set_lane(0, 200, 49, 490, 4900);
    set_lane(1, 10, 49, 680, 44800);
    set_lane(2, 200, 49, 680, 44800);
    set_lane(3, 10, 49, 490, 4900);
    push(4'b0100, "R3 R4 one test fails");
    drain();
  endtask

  task automatic t_full_range();
    set_lane(0, 65535, 49, 65535, 64'd65535 * 65535);
    set_lane(1, 65535, 49, 49 * 65535, 64'd49 * 65535 * 65535);
    set_lane(2, 65535, 49, 65535 + 48, 64'd65535 * 65535 + 48);
    set_lane(3, 1, 49, 65535, 64'd65535 * 65535);
    push({1'b0, model(65535, 49, 65535 + 48, 64'd65535 * 65535 + 48), 1'b0, 1'b1},
         "R8 full range");
    drain();
  endtask

  task automatic t_stream(int n, int seed_gap);
    for (int k = 0; k < n; k++) begin
      automatic logic [3:0] e;
      for (int i = 0; i < L; i++) begin
        automatic longint m = $urandom_range(0, 49);
        automatic longint s = 0, q = 0, p = 0;
        for (int j = 0; j < m; j++) begin
          automatic longint v = $urandom_range(0, 60);
          if (j == 0 && $urandom_range(0, 1) == 1) v = $urandom_range(100, 3000);
          if (j == 0) p = v;
          s += v; q += v * v;
        end
        set_lane(i, p, m, s, q);
        e[i] = model(p, m, s, q);
      end
      push(e, "R5 R3 R4 stream");
      if (seed_gap != 0 && (k % seed_gap) == 0) @(negedge clk);
    end
    drain();
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_mixed();
    t_pix_zero();
    t_single_test();
    t_full_range();
    t_stream(300, 0);
    t_stream(300, 7);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule